// File: doc/BRIEF.md
# Multi-Source Output Clock Divider

This block drives one clock output pin of a multi-output clock generator. A 2-bit setting input chooses one entry of a table that is fixed when the block is elaborated. Each entry names a clock source, an integer division ratio and a parking mode. The source is one of several high-speed PLL clocks, the reference clock, or none at all.

A PLL source is divided by the entry's ratio, from 2 to 16. Odd ratios still give a 50% duty cycle. The reference clock can only be passed straight through; it is never divided. An entry with no source parks the pin either at a static low level or in high impedance. The high-impedance case is modelled here by dropping an output-enable.

An active-low power-down input forces the pin at once into a parked state. That state is set by a static parameter, and the setting input cannot change it. When power-down is released, the divider starts again from the beginning of its cycle, so the first output pulse is complete. The PLLs and the pad driver lie outside the block. Source changes are expected to happen while the output is stopped or while it is treated as not yet locked.

Top module: `odiv_clk_out`

## Requirements
- R1: For a table entry whose source value is a PLL index (0 to NUM_PLL-1), the output period equals the entry's ratio times that PLL clock's period, for any ratio from 2 to 16.
- R2: With an even ratio N, the output is high for exactly N/2 source periods of every period.
- R3: With an odd ratio N, the output is high for exactly N/2 source periods (a half-period resolution), so the duty cycle is 50%.
- R4: For an entry whose source value equals NUM_PLL, the output follows the reference clock undivided, with the same period and high time, whatever ratio the entry holds.
- R5: For an entry whose source value is NUM_PLL+1 (unused), clk_o stays low, and clk_oe_o is 0 if the entry's parking flag is 1 (high impedance) and 1 if the flag is 0 (driven low).
- R6: While pwrdn_ni is 0, clk_o is low and clk_oe_o equals the inverse of PD_HIZ, whatever the setting input or that entry's parking flag. This takes effect without waiting for any clock edge.
- R7: After pwrdn_ni rises, the source clock first passes through a two-stage synchronizer. The divider then restarts from count zero: the first output rising edge comes on the third source rising edge after release for even ratios, half a source period later for odd ratios, and the first high pulse has full width.
- R8: Changing sel_i applies the source and ratio of the newly selected entry; each of the four codes can carry a different source and ratio.
- R9: While rst_ni is 0, clk_o is low and clk_oe_o follows the selected entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Reference clock; passed through undivided when selected |
| pll_clk_i | input | NUM_PLL | High-speed PLL clocks, one bit per PLL |
| rst_ni | input | 1 | Active-low asynchronous reset of the divider state |
| sel_i | input | SEL_W | Setting code that picks a table entry |
| pwrdn_ni | input | 1 | Active-low power-down |
| clk_o | output | 1 | Output clock |
| clk_oe_o | output | 1 | Output enable; 0 models a high-impedance pin |

## Verification
A counter that wraps at the wrong value shows up at once as a wrong output period. A phase register that is off by one shows up within one output period as a high time that deviates from half the period, and for odd ratios the error is a half source period. A synchronizer or restart fault moves the first rising edge after power-down release by whole source periods, or truncates the first pulse, so the bench times that edge against the release. Faults in the parking decode appear on clk_o and clk_oe_o without any clock edge being needed.

// File: rtl/odiv_pkg.sv
`timescale 1ns/1ps
package odiv_pkg;
  // which path feeds the pin for the selected table entry
  typedef enum logic [1:0] {
    PATH_DIV = 2'd0,
    PATH_REF = 2'd1,
    PATH_OFF = 2'd2
  } path_e;
endpackage

// File: rtl/odiv_src_mux.sv
`timescale 1ns/1ps
module odiv_src_mux
  import odiv_pkg::*;
#(
  parameter int unsigned NUM_PLL = 3,
  localparam int unsigned PLL_W = (NUM_PLL > 1) ? $clog2(NUM_PLL) : 1
) (
  input  logic               ref_clk_i,
  input  logic [NUM_PLL-1:0] pll_clk_i,
  input  logic [PLL_W-1:0]   pll_idx_i,
  input  path_e              path_i,
  output logic               src_clk_o
);
  logic [NUM_PLL-1:0] hit;

  for (genvar g = 0; g < NUM_PLL; g++) begin : g_pll
    assign hit[g] = pll_clk_i[g] & (pll_idx_i == PLL_W'(g));
  end

  always_comb begin
    src_clk_o = 1'b0;
    if (path_i == PATH_REF)      src_clk_o = ref_clk_i;
    else if (path_i == PATH_DIV) src_clk_o = |hit;
  end
endmodule

// File: rtl/odiv_divider.sv
`timescale 1ns/1ps
module odiv_divider #(
  parameter int unsigned DIV_W = 5
) (
  input  logic             src_clk_i,
  input  logic             rst_ni,
  input  logic             pwrdn_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             div_clk_o,
  output logic             ref_clk_o
);
  logic             sync_q, run_q;
  logic [DIV_W-1:0] cnt_q, cnt_nxt, half;
  logic             pos_q, neg_q, ref_en_q;

  // power-down release crosses into the source domain
  always_ff @(posedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      sync_q <= pwrdn_ni;
      run_q  <= sync_q;
    end
  end

  assign half    = (div_i >> 1) + {{(DIV_W-1){1'b0}}, div_i[0]};
  assign cnt_nxt = (cnt_q >= div_i - 1'b1) ? '0 : cnt_q + 1'b1;

  // stopped: park on last count so the first running edge lands on zero
  always_ff @(posedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pos_q <= 1'b0;
    end else if (!run_q) begin
      cnt_q <= div_i - 1'b1;
      pos_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      pos_q <= (cnt_nxt < half);
    end
  end

  // half-period delayed copy trims odd-ratio high time to N/2
  always_ff @(negedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      neg_q    <= 1'b0;
      ref_en_q <= 1'b0;
    end else begin
      neg_q    <= pos_q;
      ref_en_q <= run_q;
    end
  end

  assign div_clk_o = div_i[0] ? (pos_q & neg_q) : pos_q;
  assign ref_clk_o = src_clk_i & ref_en_q;

  a_r1_cnt_bound: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q) && $stable(div_i)) |-> (cnt_q < div_i));

  a_r7_restart_zero: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    $rose(run_q) |=> (cnt_q == '0));

  a_r3_half_phase: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    neg_q == pos_q);
endmodule

// File: rtl/odiv_out_stage.sv
`timescale 1ns/1ps
module odiv_out_stage
  import odiv_pkg::*;
#(
  parameter bit PD_HIZ = 1'b0
) (
  input  logic  pwrdn_ni,
  input  path_e path_i,
  input  logic  idle_hiz_i,
  input  logic  div_clk_i,
  input  logic  ref_clk_i,
  output logic  clk_o,
  output logic  oe_o
);
  always_comb begin
    clk_o = 1'b0;
    oe_o  = 1'b1;
    if (!pwrdn_ni) begin
      oe_o = !PD_HIZ;
    end else begin
      case (path_i)
        PATH_DIV: clk_o = div_clk_i;
        PATH_REF: clk_o = ref_clk_i;
        default:  oe_o  = !idle_hiz_i;
      endcase
    end
  end
endmodule

// File: rtl/odiv_clk_out.sv
`timescale 1ns/1ps
module odiv_clk_out
  import odiv_pkg::*;
#(
  parameter int unsigned NUM_PLL = 3,
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned DIV_MAX = 16,
  parameter bit          PD_HIZ  = 1'b0,
  // source value: 0..NUM_PLL-1 PLL index, NUM_PLL reference, NUM_PLL+1 unused
  parameter int unsigned SRC_TBL      [1<<SEL_W] = '{0, 1, 3, 4},
  parameter int unsigned DIV_TBL      [1<<SEL_W] = '{3, 16, 2, 2},
  parameter int unsigned IDLE_HIZ_TBL [1<<SEL_W] = '{0, 0, 0, 1}
) (
  input  logic               ref_clk_i,
  input  logic [NUM_PLL-1:0] pll_clk_i,
  input  logic               rst_ni,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               pwrdn_ni,
  output logic               clk_o,
  output logic               clk_oe_o
);
  localparam int unsigned PLL_W = (NUM_PLL > 1) ? $clog2(NUM_PLL) : 1;
  localparam int unsigned DIV_W = $clog2(DIV_MAX + 1);

  int unsigned       src_code, div_code;
  path_e             path;
  logic [PLL_W-1:0]  pll_idx;
  logic [DIV_W-1:0]  div;
  logic              idle_hiz;
  logic              src_clk, div_clk, ref_gated;

  always_comb begin
    src_code = SRC_TBL[sel_i];
    div_code = DIV_TBL[sel_i];
    idle_hiz = (IDLE_HIZ_TBL[sel_i] != 0);
    pll_idx  = '0;
    if (src_code < NUM_PLL) begin
      path    = PATH_DIV;
      pll_idx = PLL_W'(src_code);
    end else if (src_code == NUM_PLL) begin
      path = PATH_REF;
    end else begin
      path = PATH_OFF;
    end
    if (div_code < 2)            div = DIV_W'(2);
    else if (div_code > DIV_MAX) div = DIV_W'(DIV_MAX);
    else                         div = DIV_W'(div_code);
  end

  odiv_src_mux #(.NUM_PLL(NUM_PLL)) u_mux (
    .ref_clk_i (ref_clk_i),
    .pll_clk_i (pll_clk_i),
    .pll_idx_i (pll_idx),
    .path_i    (path),
    .src_clk_o (src_clk)
  );

  odiv_divider #(.DIV_W(DIV_W)) u_div (
    .src_clk_i (src_clk),
    .rst_ni    (rst_ni),
    .pwrdn_ni  (pwrdn_ni),
    .div_i     (div),
    .div_clk_o (div_clk),
    .ref_clk_o (ref_gated)
  );

  odiv_out_stage #(.PD_HIZ(PD_HIZ)) u_out (
    .pwrdn_ni   (pwrdn_ni),
    .path_i     (path),
    .idle_hiz_i (idle_hiz),
    .div_clk_i  (div_clk),
    .ref_clk_i  (ref_gated),
    .clk_o      (clk_o),
    .oe_o       (clk_oe_o)
  );

  a_r6_pd_forced: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !pwrdn_ni |-> (!clk_o && (clk_oe_o == !PD_HIZ)));

  a_r5_unused_parked: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (pwrdn_ni && path == PATH_OFF) |-> (!clk_o && (clk_oe_o == !idle_hiz)));
endmodule

// File: tb/odiv_clk_out_tb.sv
`timescale 1ns/1ps
module odiv_clk_out_tb;
  logic       ref_clk = 1'b0;
  logic [2:0] pll_clk = 3'b000;
  logic       rst_n = 1'b0;
  logic [1:0] sel_a = 2'd0, sel_b = 2'd0;
  logic       pd_a = 1'b1, pd_b = 1'b1;
  logic       clk_a, oe_a, clk_b, oe_b;
  logic       msel = 1'b0;
  logic       mon;
  int         checks = 0, fails = 0;

  always #10 ref_clk    = ~ref_clk;   // 50 MHz
  always #2  pll_clk[0] = ~pll_clk[0]; // 4 ns
  always #3  pll_clk[1] = ~pll_clk[1]; // 6 ns
  always #5  pll_clk[2] = ~pll_clk[2]; // 10 ns

  // A: PLL0/3, PLL1/16, ref, unused-low; power-down parks hi-z
  odiv_clk_out #(
    .PD_HIZ(1'b1),
    .SRC_TBL('{0, 1, 3, 4}), .DIV_TBL('{3, 16, 2, 2}), .IDLE_HIZ_TBL('{0, 0, 0, 0})
  ) u_dut (
    .ref_clk_i(ref_clk), .pll_clk_i(pll_clk), .rst_ni(rst_n), .sel_i(sel_a),
    .pwrdn_ni(pd_a), .clk_o(clk_a), .clk_oe_o(oe_a)
  );

  // B: PLL2/2, PLL0/5, PLL1/7, unused-hiz; power-down parks low
  odiv_clk_out #(
    .PD_HIZ(1'b0),
    .SRC_TBL('{2, 0, 1, 4}), .DIV_TBL('{2, 5, 7, 2}), .IDLE_HIZ_TBL('{0, 0, 0, 1})
  ) u_dut2 (
    .ref_clk_i(ref_clk), .pll_clk_i(pll_clk), .rst_ni(rst_n), .sel_i(sel_b),
    .pwrdn_ni(pd_b), .clk_o(clk_b), .clk_oe_o(oe_b)
  );

  assign mon = msel ? clk_b : clk_a;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(input logic b, output longint per, output longint hi);
    longint t0, t1, t2;
    msel = b;
    repeat (4) @(posedge mon);
    @(posedge mon) t0 = $time;
    @(negedge mon) t1 = $time;
    @(posedge mon) t2 = $time;
    per = t2 - t0;
    hi  = t1 - t0;
  endtask

  task automatic t_reset();
    #5;
    chk("R9 reset clk A", clk_a, 0);
    chk("R9 reset clk B", clk_b, 0);
    chk("R9 reset oe A", oe_a, 1);
    chk("R9 reset oe B", oe_b, 1);
    #20 rst_n = 1'b1;
  endtask

  task automatic t_entry(input logic b, input logic [1:0] code, input longint ep,
                         input longint eh, input string tag);
    longint per, hi;
    if (b) sel_b = code; else sel_a = code;
    measure(b, per, hi);
    chk({tag, " R1 R8 period"}, per, ep);
    chk({tag, " high time"}, hi, eh);
  endtask

  task automatic t_unused();
    sel_a = 2'd3; sel_b = 2'd3;
    #53;
    for (int k = 0; k < 4; k++) begin
      chk("R5 unused clk A", clk_a, 0);
      chk("R5 unused clk B", clk_b, 0);
      #7;
    end
    chk("R5 unused driven-low oe A", oe_a, 1);
    chk("R5 unused hi-z oe B", oe_b, 0);
  endtask

  task automatic t_powerdown();
    sel_a = 2'd0; sel_b = 2'd3;
    #101;
    pd_a = 1'b0; pd_b = 1'b0;
    #1;
    chk("R6 pd clk A", clk_a, 0);
    chk("R6 pd oe A", oe_a, 0);
    chk("R6 pd oe B overrides idle", oe_b, 1);
    #97;
    chk("R6 pd clk A held", clk_a, 0);
    chk("R6 pd clk B held", clk_b, 0);
  endtask

  task automatic t_restart_a();
    longint t, tr, tf;
    @(posedge pll_clk[0]) t = $time;
    #0.5 pd_a = 1'b1;
    @(posedge clk_a) tr = $time;
    @(negedge clk_a) tf = $time;
    chk("R7 odd first edge A", tr - t, 14);
    chk("R7 odd first pulse A", tf - tr, 6);
  endtask

  task automatic t_restart_b();
    longint t, tr, tf;
    sel_b = 2'd0;
    #50;
    @(posedge pll_clk[2]) t = $time;
    #0.5 pd_b = 1'b1;
    @(posedge clk_b) tr = $time;
    @(negedge clk_b) tf = $time;
    chk("R7 even first edge B", tr - t, 30);
    chk("R7 even first pulse B", tf - tr, 10);
  endtask

  initial begin
    #1_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_entry(1'b0, 2'd0, 12, 6,  "R3 A pll0/3");
    t_entry(1'b0, 2'd1, 96, 48, "R2 A pll1/16");
    t_entry(1'b0, 2'd2, 20, 10, "R4 A ref");
    t_entry(1'b1, 2'd0, 20, 10, "R2 B pll2/2");
    t_entry(1'b1, 2'd1, 20, 10, "R3 B pll0/5");
    t_entry(1'b1, 2'd2, 42, 21, "R3 B pll1/7");
    t_unused();
    t_powerdown();
    t_restart_a();
    t_restart_b();
    t_entry(1'b0, 2'd1, 96, 48, "R2 A back to pll1/16");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule